// File: doc/BRIEF.md
# Clock Emergency and Wake-up Controller

This block is the sequencing core of a microcontroller clock system. It decides which clock source drives the system after a reset, after a sleep wake-up and after a loss of the oscillator. It also decides which output divider is in effect at each point. The analog PLL, the VCO and the glitch-free clock multiplexer sit outside the block. The block steers them through a source-select code and an effective divider value.

Two inputs set the wake-up path: the 2-bit PLL mode and whether the main oscillator stayed on during sleep. The oscillator stays on when the real-time clock runs from it. Emergency operation runs from the VCO base frequency divided by 16 and forces the divider to its all-ones value. It lasts until a lock counter has seen a full run of oscillator-present cycles. The controller holds off sleep requests while the effective divider is all-ones, so the clock is only gated once any reconfiguration has finished.

Top module: `clk_recover_ctrl`

## Requirements
- R1: A hardware reset (`rst_n` low) sets normal run with mode 00 and divider 0. With the oscillator present, this gives `clk_sel`=1, `div_eff`=0, `emerg`=0 and `sleep_ok`=0.
- R2: While awake and not in emergency, a configuration write is in effect on the next cycle, and `div_eff` equals the written divider. Mode encoding: 00 is bypass with VCO off, 01 is bypass with VCO on, 10 is PLL with the oscillator input disconnected, 11 is PLL with the oscillator input connected. `clk_sel` is 1 (oscillator direct) for modes 00 and 01 and 3 (PLL) for modes 10 and 11.
- R3: The block grants sleep (`sleep_ok`=1, `clk_sel`=0 for no clock) one cycle after `sleep_req` is sampled in normal run, provided `div_eff` is not 15. While `div_eff` is 15, including emergency, the request is held off.
- R4: If `rtc_on_main` was 1 at sleep entry (oscillator kept running), a wake event in modes 00, 01 or 11 returns the block to normal run on the next cycle.
- R5: In mode 10 with the oscillator kept running, a wake event is refused and the block stays asleep.
- R6: If the oscillator was off during sleep, a wake event in modes 01, 10 or 11 enters emergency: `clk_sel`=2 (VCO base divided by 16), `div_eff`=15, `emerg`=1.
- R7: In mode 00 with the oscillator off during sleep, a wake event gives `clk_sel`=0 and `emerg`=0. The block stays there until `osc_ok` is sampled high, and then returns to `clk_sel`=1 on the next cycle.
- R8: Emergency ends on the LOCK_TICKS-th consecutive cycle (default 2048) in which `osc_ok` is sampled high. A cycle with `osc_ok` low clears the count.
- R9: During emergency, a write with a PLL mode (10 or 11) is stored, and its divider becomes effective only at lock, while `div_eff` stays 15. A write with a bypass mode (00 or 01) during emergency is discarded.
- R10: While awake, `osc_ok` sampled low sends the block to emergency in modes 01 and 11, and to the no-clock stall of R7 in mode 00. Mode 10 keeps running.
- R11: A `sw_rst` pulse returns the block to normal run on the next cycle and keeps the stored mode and divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Hardware or watchdog reset, active low, asynchronous |
| sw_rst | input | 1 | Software reset pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | PLL mode to write |
| cfg_div | input | DIV_W | Output divider to write |
| osc_ok | input | 1 | Main oscillator delivers a valid clock |
| rtc_on_main | input | 1 | Real-time clock runs from the main oscillator |
| sleep_req | input | 1 | Request to enter sleep |
| wake_evt | input | 1 | Wake-up event |
| clk_sel | output | 2 | Source select: 0 none, 1 oscillator, 2 VCO base/16, 3 PLL |
| div_eff | output | DIV_W | Divider currently in effect |
| emerg | output | 1 | Emergency mode status |
| sleep_ok | output | 1 | Sleep granted, clock gated |

## Verification
The assertions assume that every input is synchronous to `clk` and holds one clean value per cycle. They also assume that `sw_rst` is only pulsed while `rst_n` is high. The lock-length property additionally relies on `osc_ok` being the only qualifier of the lock count, so it counts emergency cycles with `osc_ok` high on its own. The stimulus changes every input on the falling edge only and applies software reset as a one-cycle pulse outside hardware reset. It drops `osc_ok` deliberately only where a requirement calls for it, including once in the middle of a lock run.

// File: rtl/clk_recover_pkg.sv
package clk_recover_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_STALL = 2'd2,
        ST_EMERG = 2'd3
    } cr_state_e;

    typedef enum logic [1:0] {
        WK_RUN   = 2'd0,
        WK_STALL = 2'd1,
        WK_EMERG = 2'd2,
        WK_HOLD  = 2'd3
    } cr_wake_e;

    localparam logic [1:0] SRC_NONE = 2'd0;
    localparam logic [1:0] SRC_OSC  = 2'd1;
    localparam logic [1:0] SRC_VCO  = 2'd2;
    localparam logic [1:0] SRC_PLL  = 2'd3;

    localparam logic [1:0] MODE_BYP_VCO_OFF = 2'b00;
    localparam logic [1:0] MODE_BYP_VCO_ON  = 2'b01;
    localparam logic [1:0] MODE_PLL_NO_IN   = 2'b10;
    localparam logic [1:0] MODE_PLL_IN      = 2'b11;

endpackage

// File: rtl/clk_recover_lock.sv
module clk_recover_lock #(
    parameter int LOCK_TICKS = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    output logic lock_done
);
    localparam int CW = $clog2(LOCK_TICKS);
    localparam logic [CW-1:0] LAST = CW'(LOCK_TICKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    // The count advances only on consecutive qualified cycles; any gap clears it.
    always_comb begin
        lock_done = count_en && (cnt_q == LAST);
        if (!count_en || lock_done) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/clk_recover_wake.sv
module clk_recover_wake
    import clk_recover_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       osc_kept,
    output cr_wake_e   wake_to
);
    always_comb begin
        if (osc_kept) begin
            // The disconnected-input PLL mode cannot leave sleep while the oscillator runs.
            wake_to = (mode == MODE_PLL_NO_IN) ? WK_HOLD : WK_RUN;
        end else begin
            wake_to = (mode == MODE_BYP_VCO_OFF) ? WK_STALL : WK_EMERG;
        end
    end
endmodule

// File: rtl/clk_recover_omap.sv
module clk_recover_omap
    import clk_recover_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  cr_state_e        st,
    input  logic [1:0]       mode,
    input  logic [DIV_W-1:0] div,
    output logic [1:0]       clk_sel,
    output logic [DIV_W-1:0] div_eff,
    output logic             emerg,
    output logic             sleep_ok
);
    always_comb begin
        clk_sel  = SRC_NONE;
        div_eff  = div;
        emerg    = 1'b0;
        sleep_ok = 1'b0;
        unique case (st)
            ST_RUN: begin
                clk_sel = mode[1] ? SRC_PLL : SRC_OSC;
            end
            ST_SLEEP: begin
                sleep_ok = 1'b1;
            end
            ST_STALL: begin
                clk_sel = SRC_NONE;
            end
            ST_EMERG: begin
                clk_sel = SRC_VCO;
                div_eff = '1;
                emerg   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/clk_recover_ctrl.sv
module clk_recover_ctrl
    import clk_recover_pkg::*;
#(
    parameter int DIV_W      = 4,
    parameter int LOCK_TICKS = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_mode,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             osc_ok,
    input  logic             rtc_on_main,
    input  logic             sleep_req,
    input  logic             wake_evt,
    output logic [1:0]       clk_sel,
    output logic [DIV_W-1:0] div_eff,
    output logic             emerg,
    output logic             sleep_ok
);
    localparam logic [DIV_W-1:0] DIV_RECONF = '1;
    localparam logic [DIV_W-1:0] DIV_RESET  = '0;

    typedef struct packed {
        cr_state_e        st;
        logic [1:0]       mode;
        logic [DIV_W-1:0] div;
        logic             osc_kept;
    } cr_regs_t;

    cr_regs_t r_d, r_q;
    cr_wake_e wake_to;
    logic     lock_en;
    logic     lock_done;

    clk_recover_lock #(.LOCK_TICKS(LOCK_TICKS)) i_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_en  (lock_en),
        .lock_done (lock_done)
    );

    clk_recover_wake i_wake (
        .mode     (r_q.mode),
        .osc_kept (r_q.osc_kept),
        .wake_to  (wake_to)
    );

    clk_recover_omap #(.DIV_W(DIV_W)) i_omap (
        .st       (r_q.st),
        .mode     (r_q.mode),
        .div      (r_q.div),
        .clk_sel  (clk_sel),
        .div_eff  (div_eff),
        .emerg    (emerg),
        .sleep_ok (sleep_ok)
    );

    always_comb begin
        r_d     = r_q;
        lock_en = (r_q.st == ST_EMERG) && osc_ok && !sw_rst;

        if (sw_rst) begin
            // Software reset keeps the stored configuration.
            r_d.st = ST_RUN;
        end else begin
            // In emergency only PLL-mode writes are accepted; their divider waits for lock.
            if (cfg_we && ((r_q.st != ST_EMERG) || cfg_mode[1])) begin
                r_d.mode = cfg_mode;
                r_d.div  = cfg_div;
            end

            unique case (r_q.st)
                ST_RUN: begin
                    if (!osc_ok && (r_q.mode != MODE_PLL_NO_IN)) begin
                        r_d.st = (r_q.mode == MODE_BYP_VCO_OFF) ? ST_STALL : ST_EMERG;
                    end else if (sleep_req && (div_eff != DIV_RECONF)) begin
                        r_d.st       = ST_SLEEP;
                        r_d.osc_kept = rtc_on_main;
                    end
                end
                ST_SLEEP: begin
                    if (wake_evt) begin
                        unique case (wake_to)
                            WK_RUN:   r_d.st = ST_RUN;
                            WK_STALL: r_d.st = ST_STALL;
                            WK_EMERG: r_d.st = ST_EMERG;
                            WK_HOLD:  r_d.st = ST_SLEEP;
                        endcase
                    end
                end
                ST_STALL: begin
                    if (osc_ok) begin
                        r_d.st = ST_RUN;
                    end
                end
                ST_EMERG: begin
                    if (lock_done) begin
                        r_d.st = ST_RUN;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_RUN;
            r_q.mode     <= MODE_BYP_VCO_OFF;
            r_q.div      <= DIV_RESET;
            r_q.osc_kept <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/clk_recover_chk.sv
module clk_recover_chk
    import clk_recover_pkg::*;
#(
    parameter int DIV_W      = 4,
    parameter int LOCK_TICKS = 2048
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_rst,
    input logic             osc_ok,
    input logic             sleep_req,
    input logic [1:0]       clk_sel,
    input logic [DIV_W-1:0] div_eff,
    input logic             emerg,
    input logic             sleep_ok
);
    int run_q;

    // Independent count of emergency cycles with the oscillator present.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 0;
        end else if (emerg && osc_ok) begin
            run_q <= (run_q < LOCK_TICKS) ? run_q + 1 : run_q;
        end else begin
            run_q <= 0;
        end
    end

    p_emerg_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        emerg |-> (div_eff == '1) && (clk_sel == SRC_VCO));

    p_sleep_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_ok) |-> $past(sleep_req) && ($past(div_eff) != '1));

    p_sleep_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_ok |-> (clk_sel == SRC_NONE) && !emerg);

    p_lock_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(emerg) && !$past(sw_rst)) |-> ($past(run_q) == LOCK_TICKS - 1) && $past(osc_ok));

    p_sw_rst_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> !emerg && !sleep_ok && (clk_sel != SRC_NONE));
endmodule

bind clk_recover_ctrl clk_recover_chk #(.DIV_W(DIV_W), .LOCK_TICKS(LOCK_TICKS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_rst    (sw_rst),
    .osc_ok    (osc_ok),
    .sleep_req (sleep_req),
    .clk_sel   (clk_sel),
    .div_eff   (div_eff),
    .emerg     (emerg),
    .sleep_ok  (sleep_ok)
);

// File: tb/test_clk_recover_ctrl.sv
module test_clk_recover_ctrl;
    localparam int DIV_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sw_rst = 1'b0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_mode = 2'b00;
    logic [DIV_W-1:0] cfg_div = '0;
    logic             osc_ok = 1'b1;
    logic             rtc_on_main = 1'b0;
    logic             sleep_req = 1'b0;
    logic             wake_evt = 1'b0;
    logic [1:0]       clk_sel;
    logic [DIV_W-1:0] div_eff;
    logic             emerg;
    logic             sleep_ok;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #10ns clk = ~clk;

    clk_recover_ctrl #(.DIV_W(DIV_W), .LOCK_TICKS(2048)) i_clk_recover_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_rst      (sw_rst),
        .cfg_we      (cfg_we),
        .cfg_mode    (cfg_mode),
        .cfg_div     (cfg_div),
        .osc_ok      (osc_ok),
        .rtc_on_main (rtc_on_main),
        .sleep_req   (sleep_req),
        .wake_evt    (wake_evt),
        .clk_sel     (clk_sel),
        .div_eff     (div_eff),
        .emerg       (emerg),
        .sleep_ok    (sleep_ok)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [1:0] m, input logic [DIV_W-1:0] d);
        cfg_we = 1'b1; cfg_mode = m; cfg_div = d;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic enter_sleep(input logic rtc);
        rtc_on_main = rtc;
        sleep_req = 1'b1;
        tick(1);
        sleep_req = 1'b0;
        check("R3", "sleep_ok at entry", sleep_ok, 1);
    endtask

    task automatic wake();
        wake_evt = 1'b1;
        tick(1);
        wake_evt = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "clk_sel", clk_sel, 1);
        check("R1", "div_eff", div_eff, 0);
        check("R1", "emerg", emerg, 0);
        check("R1", "sleep_ok", sleep_ok, 0);
    endtask

    task automatic t_run_cfg();
        write_cfg(2'b11, 4'd3);
        check("R2", "clk_sel pll", clk_sel, 3);
        check("R2", "div_eff", div_eff, 3);
        write_cfg(2'b01, 4'd6);
        check("R2", "clk_sel osc", clk_sel, 1);
        check("R2", "div_eff", div_eff, 6);
    endtask

    task automatic t_sleep_gate();
        write_cfg(2'b11, 4'd15);
        sleep_req = 1'b1;
        tick(3);
        check("R3", "held off at div 15", sleep_ok, 0);
        write_cfg(2'b11, 4'd2);
        tick(1);
        check("R3", "granted", sleep_ok, 1);
        check("R3", "clk_sel none", clk_sel, 0);
        sleep_req = 1'b0;
    endtask

    task automatic t_wake_kept();
        // Asleep from t_sleep_gate with rtc_on_main=1 at entry.
        wake();
        check("R4", "clk_sel", clk_sel, 3);
        check("R4", "div_eff", div_eff, 2);
        check("R4", "sleep_ok", sleep_ok, 0);
    endtask

    task automatic t_refuse_and_swrst();
        write_cfg(2'b10, 4'd1);
        enter_sleep(1'b1);
        wake();
        check("R5", "still asleep", sleep_ok, 1);
        check("R5", "clk_sel none", clk_sel, 0);
        sw_rst = 1'b1;
        tick(1);
        sw_rst = 1'b0;
        check("R11", "clk_sel", clk_sel, 3);
        check("R11", "div_eff kept", div_eff, 1);
        check("R11", "sleep_ok", sleep_ok, 0);
    endtask

    task automatic t_emerg_wake();
        write_cfg(2'b11, 4'd4);
        enter_sleep(1'b0);
        osc_ok = 1'b0;
        wake();
        check("R6", "clk_sel vco", clk_sel, 2);
        check("R6", "div_eff", div_eff, 15);
        check("R6", "emerg", emerg, 1);
        sleep_req = 1'b1;
        tick(2);
        check("R3", "held off in emergency", sleep_ok, 0);
        sleep_req = 1'b0;
        write_cfg(2'b11, 4'd5);
        check("R9", "div_eff stays 15", div_eff, 15);
        write_cfg(2'b00, 4'd7);
        osc_ok = 1'b1;
        tick(1000);
        osc_ok = 1'b0;
        tick(1);
        osc_ok = 1'b1;
        tick(2047);
        check("R8", "emerg before full count", emerg, 1);
        tick(1);
        check("R8", "emerg after full count", emerg, 0);
        check("R9", "clk_sel pll kept", clk_sel, 3);
        check("R9", "divider from stored write", div_eff, 5);
    endtask

    task automatic t_stall();
        write_cfg(2'b00, 4'd4);
        enter_sleep(1'b0);
        osc_ok = 1'b0;
        wake();
        check("R7", "clk_sel none", clk_sel, 0);
        check("R7", "emerg", emerg, 0);
        check("R7", "sleep_ok", sleep_ok, 0);
        tick(5);
        check("R7", "still stalled", clk_sel, 0);
        osc_ok = 1'b1;
        tick(1);
        check("R7", "clk_sel osc", clk_sel, 1);
        check("R7", "div_eff", div_eff, 4);
    endtask

    task automatic t_fail();
        write_cfg(2'b01, 4'd2);
        osc_ok = 1'b0;
        tick(1);
        check("R10", "emerg on loss", emerg, 1);
        check("R10", "clk_sel vco", clk_sel, 2);
        osc_ok = 1'b1;
        tick(2048);
        check("R10", "recovered emerg", emerg, 0);
        check("R10", "recovered clk_sel", clk_sel, 1);
        check("R10", "recovered div", div_eff, 2);
        write_cfg(2'b00, 4'd3);
        osc_ok = 1'b0;
        tick(1);
        check("R10", "mode 00 stall", clk_sel, 0);
        check("R10", "mode 00 no emerg", emerg, 0);
        osc_ok = 1'b1;
        tick(1);
        check("R10", "mode 00 back", clk_sel, 1);
        write_cfg(2'b10, 4'd3);
        osc_ok = 1'b0;
        tick(2);
        check("R10", "mode 10 keeps pll", clk_sel, 3);
        check("R10", "mode 10 no emerg", emerg, 0);
        osc_ok = 1'b1;
    endtask

    task automatic t_swrst_emerg();
        write_cfg(2'b11, 4'd6);
        osc_ok = 1'b0;
        tick(1);
        check("R10", "emerg", emerg, 1);
        osc_ok = 1'b1;
        sw_rst = 1'b1;
        tick(1);
        sw_rst = 1'b0;
        check("R11", "emerg cleared", emerg, 0);
        check("R11", "clk_sel", clk_sel, 3);
        check("R11", "div kept", div_eff, 6);
    endtask

    task automatic t_hw_reset();
        rst_n = 1'b0;
        tick(1);
        check("R1", "clk_sel after reset", clk_sel, 1);
        check("R1", "div after reset", div_eff, 0);
        rst_n = 1'b1;
        tick(1);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_run_cfg();
        rtc_on_main = 1'b1;
        t_sleep_gate();
        t_wake_kept();
        t_refuse_and_swrst();
        t_emerg_wake();
        t_stall();
        t_fail();
        t_swrst_emerg();
        t_hw_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(20ns * 100000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule